// File: doc/BRIEF.md
# UART Transmit Framer

This block takes characters from a small transmit queue and shifts them out on a serial line, one bit per sixteen baud-rate ticks. A set of static format inputs selects how many data bits go out, whether a parity bit is added and how it is formed (even, odd or forced to a constant), and whether the frame ends with one or two stop bits. A send-break input pulls the line low once the character on the wire has finished.

The queue either works as a FIFO of `DEPTH` entries or shrinks to a single holding register, depending on a mode input. A character leaves the queue only while the block and its transmit path are both enabled, no break is requested, and, when flow control is switched on, the active-low clear-to-send input is asserted. Clearing any of these gates mid-frame never cuts a character short. The busy flag shows pending or in-flight work even while the transmitter is disabled. Baud-rate generation and register access sit outside this block.

Top module: `uart_tx_framer`

## Requirements
- R1: The 2-bit `word_len` code selects the data-bit count: 0 gives 5 bits, 1 gives 6, 2 gives 7 and 3 gives 8; data goes out least significant bit first.
- R2: A frame is one low start bit, the data bits, an optional parity bit, then one high stop bit, or two when `two_stop` is 1; the line is high when idle.
- R3: With `parity_en` = 1 and `stick_par` = 0, `even_par` = 1 makes the count of ones over data and parity even, and `even_par` = 0 makes it odd.
- R4: With `parity_en` = 1 and `stick_par` = 1, the parity bit is 1 when `even_par` = 0 and 0 when `even_par` = 1; with `parity_en` = 0, `stick_par` adds no bit.
- R5: Each bit lasts exactly `OSR` (16) cycles on which `baud_tick` is high; without ticks the line holds its current bit.
- R6: When `send_break` is 1 the character in progress finishes unchanged, then `txd` stays low and no queued character starts; clearing it returns the line high.
- R7: Clearing `tx_en` during a frame lets the frame complete; no new character starts until both `uart_en` and `tx_en` are 1 again.
- R8: `busy` is 1 from the cycle after a character is accepted, whatever the enables, and falls in the same cycle the last stop bit of the last character ends.
- R9: With `fifo_en` = 0 the queue holds one character: `tx_full` = 1 and `tx_empty` = 0 while it is held, and a push while full is dropped.
- R10: With `fifo_en` = 1 the queue holds `DEPTH` characters sent in push order; `tx_full` is 1 at `DEPTH` entries and a push while full is dropped.
- R11: With `cts_flow_en` = 1 a character starts only while `cts_n` is 0.
- R12: After reset `txd` = 1, `busy` = 0, `tx_empty` = 1 and `tx_full` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_tick | input | 1 | One-cycle enable at 16 times the bit rate |
| uart_en | input | 1 | Block enable |
| tx_en | input | 1 | Transmit path enable |
| fifo_en | input | 1 | 1: queue of DEPTH entries, 0: single holding register |
| word_len | input | 2 | Data-bit count code |
| parity_en | input | 1 | Adds a parity bit |
| even_par | input | 1 | Parity sense select |
| stick_par | input | 1 | Forces a constant parity bit |
| two_stop | input | 1 | Two stop bits |
| send_break | input | 1 | Hold the line low after the current character |
| cts_flow_en | input | 1 | Gate starts on clear-to-send |
| cts_n | input | 1 | Clear-to-send, active low |
| push_valid | input | 1 | Write strobe for push_data |
| push_data | input | 8 | Character to queue |
| txd | output | 1 | Serial output |
| busy | output | 1 | Queue non-empty or frame on the wire |
| tx_empty | output | 1 | Queue empty |
| tx_full | output | 1 | Queue full |

## Verification
On every cycle the assertions check that the queue never holds more than its capacity in either mode, that a character is only dequeued while every start gate (enables, break, clear-to-send) allows it, that a frame once started keeps running to its last tick, that the line holds still between baud ticks, and that the last bit before a frame ends is high. The exact bit pattern of each format, the parity values, the 16-tick bit length, the order of characters through the FIFO, dropped pushes, and the break and disable sequences can only be shown by the bench's scenarios, which sample the line at mid-bit and compare whole frames.

// File: rtl/uart_txf_pkg.sv
package uart_txf_pkg;

  localparam int FRAME_W = 12;

  typedef struct packed {
    logic [1:0] wlen;
    logic       par_en;
    logic       even_sel;
    logic       stick;
    logic       two_stop;
  } fmt_t;

  // start + (5 + wlen) data + parity + one or two stops
  function automatic logic [3:0] frame_bits(fmt_t f);
    return 4'd7 + {2'b00, f.wlen} + {3'b000, f.par_en} + {3'b000, f.two_stop};
  endfunction

  function automatic logic [7:0] data_mask(logic [1:0] wlen);
    return 8'hFF >> (2'd3 - wlen);
  endfunction

  function automatic logic parity_bit(fmt_t f, logic [7:0] d);
    logic x;
    x = ^(d & data_mask(f.wlen));
    if (f.stick) return ~f.even_sel;
    return f.even_sel ? x : ~x;
  endfunction

  // bit 0 is sent first; unused upper bits stay high
  function automatic logic [FRAME_W-1:0] build_frame(fmt_t f, logic [7:0] d);
    logic [FRAME_W-1:0] fr;
    int ndata;
    fr    = '1;
    fr[0] = 1'b0;
    ndata = 5 + int'(f.wlen);
    for (int i = 0; i < 8; i++) begin
      if (i < ndata) fr[i+1] = d[i];
    end
    if (f.par_en) fr[ndata+1] = parity_bit(f, d);
    return fr;
  endfunction

endpackage

// File: rtl/uart_txf_queue.sv
module uart_txf_queue #(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fifo_en,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop,
  output logic [DATA_W-1:0] head_data,
  output logic              empty,
  output logic              full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wptr, rptr;
  logic [CW-1:0]     cnt;
  logic [CW-1:0]     cap;
  logic              accept_evt;
  logic              take_evt;

  assign cap        = fifo_en ? CW'(DEPTH) : CW'(1);
  assign empty      = (cnt == '0);
  assign full       = (cnt >= cap);
  assign accept_evt = push && !full;
  assign take_evt   = pop && !empty;
  assign head_data  = mem[rptr];

  function automatic logic [AW-1:0] ptr_next(logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (accept_evt) mem[wptr] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
    end else begin
      if (accept_evt) wptr <= ptr_next(wptr);
      if (take_evt)   rptr <= ptr_next(rptr);
      case ({accept_evt, take_evt})
        2'b10:   cnt <= cnt + CW'(1);
        2'b01:   cnt <= cnt - CW'(1);
        default: cnt <= cnt;
      endcase
    end
  end

  assert_no_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH));

  assert_single_entry_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!fifo_en && $past(!fifo_en) && ($past(cnt) <= CW'(1))) |-> (cnt <= CW'(1)));

endmodule

// File: rtl/uart_txf_shifter.sv
module uart_txf_shifter
  import uart_txf_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       baud_tick,
  input  logic       req,
  input  fmt_t       fmt,
  input  logic [7:0] data,
  input  logic       send_break,
  output logic       pop,
  output logic       active,
  output logic       txd
);
  localparam int TW = (OSR > 1) ? $clog2(OSR) : 1;

  logic [FRAME_W-1:0] shreg;
  logic [3:0]         bit_idx;
  logic [3:0]         nbits;
  logic [TW-1:0]      tick_cnt;
  logic               last_tick;
  logic               frame_end;

  assign pop       = req && !active;
  assign last_tick = active && baud_tick && (tick_cnt == TW'(OSR - 1));
  assign frame_end = last_tick && (bit_idx == nbits - 4'd1);
  assign txd       = active ? shreg[0] : ~send_break;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active   <= 1'b0;
      shreg    <= '1;
      bit_idx  <= '0;
      nbits    <= '0;
      tick_cnt <= '0;
    end else if (pop) begin
      active   <= 1'b1;
      shreg    <= build_frame(fmt, data);
      nbits    <= frame_bits(fmt);
      bit_idx  <= '0;
      tick_cnt <= '0;
    end else if (active && baud_tick) begin
      if (last_tick) begin
        tick_cnt <= '0;
        if (frame_end) begin
          active <= 1'b0;
        end else begin
          shreg   <= {1'b1, shreg[FRAME_W-1:1]};
          bit_idx <= bit_idx + 4'd1;
        end
      end else begin
        tick_cnt <= tick_cnt + TW'(1);
      end
    end
  end

  assert_frame_runs_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !frame_end) |=> active);

  assert_hold_without_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !baud_tick) |=> $stable(txd));

  assert_ends_on_stop_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(active) |-> $past(txd));

endmodule

// File: rtl/uart_tx_framer.sv
module uart_tx_framer
  import uart_txf_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int OSR   = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       baud_tick,
  input  logic       uart_en,
  input  logic       tx_en,
  input  logic       fifo_en,
  input  logic [1:0] word_len,
  input  logic       parity_en,
  input  logic       even_par,
  input  logic       stick_par,
  input  logic       two_stop,
  input  logic       send_break,
  input  logic       cts_flow_en,
  input  logic       cts_n,
  input  logic       push_valid,
  input  logic [7:0] push_data,
  output logic       txd,
  output logic       busy,
  output logic       tx_empty,
  output logic       tx_full
);
  fmt_t       fmt;
  logic [7:0] head_data;
  logic       q_empty;
  logic       q_full;
  logic       start_req;
  logic       pop;
  logic       active;

  assign fmt = '{wlen: word_len, par_en: parity_en, even_sel: even_par,
                 stick: stick_par, two_stop: two_stop};

  assign start_req = !q_empty && uart_en && tx_en && !send_break &&
                     (!cts_flow_en || !cts_n);

  uart_txf_queue #(.DEPTH(DEPTH), .DATA_W(8)) u_queue (
    .clk       (clk),
    .rst_n     (rst_n),
    .fifo_en   (fifo_en),
    .push      (push_valid),
    .push_data (push_data),
    .pop       (pop),
    .head_data (head_data),
    .empty     (q_empty),
    .full      (q_full)
  );

  uart_txf_shifter #(.OSR(OSR)) u_shift (
    .clk        (clk),
    .rst_n      (rst_n),
    .baud_tick  (baud_tick),
    .req        (start_req),
    .fmt        (fmt),
    .data       (head_data),
    .send_break (send_break),
    .pop        (pop),
    .active     (active),
    .txd        (txd)
  );

  assign busy     = !q_empty || active;
  assign tx_empty = q_empty;
  assign tx_full  = q_full;

  assert_cts_gate_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && cts_flow_en) |-> !cts_n);

  assert_start_enabled_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (uart_en && tx_en && !tx_empty));

  assert_no_start_in_break_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !send_break);

  assert_busy_when_disabled_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_empty && !uart_en) |-> busy);

endmodule

// File: tb/sim_uart_tx_framer.sv
module sim_uart_tx_framer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       baud_tick = 1'b1;
  logic       uart_en = 1'b1, tx_en = 1'b1, fifo_en = 1'b1;
  logic [1:0] word_len = 2'd3;
  logic       parity_en = 1'b0, even_par = 1'b0, stick_par = 1'b0, two_stop = 1'b0;
  logic       send_break = 1'b0, cts_flow_en = 1'b0, cts_n = 1'b1;
  logic       push_valid = 1'b0;
  logic [7:0] push_data = 8'h00;
  logic       txd, busy, tx_empty, tx_full;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  uart_tx_framer u0 (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .uart_en(uart_en),
    .tx_en(tx_en), .fifo_en(fifo_en), .word_len(word_len),
    .parity_en(parity_en), .even_par(even_par), .stick_par(stick_par),
    .two_stop(two_stop), .send_break(send_break), .cts_flow_en(cts_flow_en),
    .cts_n(cts_n), .push_valid(push_valid), .push_data(push_data),
    .txd(txd), .busy(busy), .tx_empty(tx_empty), .tx_full(tx_full)
  );

  // {wlen[13:12], parity_en[11], even[10], stick[9], two_stop[8], data[7:0]}
  localparam int NVEC = 9;
  localparam logic [13:0] VECS [NVEC] = '{
    {2'd3, 4'b0000, 8'hA5},
    {2'd0, 4'b0000, 8'h13},
    {2'd1, 4'b1100, 8'h2C},
    {2'd2, 4'b1000, 8'h55},
    {2'd3, 4'b1101, 8'h81},
    {2'd3, 4'b1010, 8'h00},
    {2'd1, 4'b1110, 8'h3F},
    {2'd2, 4'b1001, 8'h7F},
    {2'd3, 4'b0010, 8'h42}
  };

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic void exp_frame(input logic [13:0] v, output logic [11:0] fr,
                                    output int n);
    int dbits, ones;
    dbits = 5 + int'(v[13:12]);
    ones  = 0;
    fr    = '0;
    for (int i = 0; i < dbits; i++) begin
      fr[1+i] = v[i];
      ones += int'(v[i]);
    end
    n = 1 + dbits;
    if (v[11]) begin
      if (v[9]) fr[n] = ~v[10];
      else      fr[n] = v[10] ? logic'(ones % 2) : logic'((ones % 2) == 0);
      n++;
    end
    fr[n] = 1'b1; n++;
    if (v[8]) begin fr[n] = 1'b1; n++; end
  endfunction

  task automatic apply_fmt(input logic [13:0] v);
    @(negedge clk);
    word_len  = v[13:12];
    parity_en = v[11];
    even_par  = v[10];
    stick_par = v[9];
    two_stop  = v[8];
  endtask

  task automatic push(input logic [7:0] d);
    @(negedge clk);
    push_valid = 1'b1;
    push_data  = d;
    @(negedge clk);
    push_valid = 1'b0;
  endtask

  // action: 1 clears tx_en, 2 sets send_break, taken at bit act_bit
  task automatic capture(input int n, input int act_bit, input int action,
                         output logic [11:0] fr);
    int waited;
    fr = '0;
    waited = 0;
    while (txd !== 1'b0 && waited < 3000) begin
      @(negedge clk);
      waited++;
    end
    repeat (8) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      if (i > 0) repeat (16) @(negedge clk);
      fr[i] = txd;
      if (i == act_bit && action == 1) tx_en = 1'b0;
      if (i == act_bit && action == 2) send_break = 1'b1;
    end
    check(busy === 1'b1, "R8 busy during last stop bit", int'(busy), 1);
    repeat (8) @(negedge clk);
  endtask

  task automatic frame_test(input logic [13:0] v, input string tag,
                            input int act_bit, input int action);
    logic [11:0] ef, got, mask;
    int n;
    exp_frame(v, ef, n);
    capture(n, act_bit, action, got);
    mask = 12'hFFF >> (12 - n);
    check((got & mask) === (ef & mask), tag, int'(got & mask), int'(ef & mask));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=0x0 expected=0x1");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [11:0] ef, got;
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12 reset state
    check(txd === 1'b1, "R12 txd idle", int'(txd), 1);
    check(busy === 1'b0, "R12 busy", int'(busy), 0);
    check(tx_empty === 1'b1, "R12 empty", int'(tx_empty), 1);
    check(tx_full === 1'b0, "R12 full", int'(tx_full), 0);

    // R1 R2 R3 R4 format table
    for (int k = 0; k < NVEC; k++) begin
      apply_fmt(VECS[k]);
      push(VECS[k][7:0]);
      frame_test(VECS[k], "R1 R2 R3 R4 frame", -1, 0);
      check(busy === 1'b0, "R8 busy falls at frame end", int'(busy), 0);
      check(txd === 1'b1, "R2 idle after stop", int'(txd), 1);
    end

    // R5 bit length and tick gating
    apply_fmt({2'd3, 4'b0000, 8'h01});
    push(8'h01);
    while (txd !== 1'b0) @(negedge clk);
    repeat (15) @(negedge clk);
    check(txd === 1'b0, "R5 start bit at tick 15", int'(txd), 0);
    @(negedge clk);
    check(txd === 1'b1, "R5 first data bit at tick 16", int'(txd), 1);
    baud_tick = 1'b0;
    repeat (60) @(negedge clk);
    check(txd === 1'b1 && busy === 1'b1, "R5 frozen without ticks",
          int'({busy, txd}), 3);
    baud_tick = 1'b1;
    repeat (200) @(negedge clk);
    check(txd === 1'b1 && busy === 1'b0, "R5 finishes after ticks resume",
          int'({busy, txd}), 1);

    // R6 break after current character
    apply_fmt({2'd3, 4'b0000, 8'h5A});
    push(8'h5A);
    push(8'hC3);
    frame_test({2'd3, 4'b0000, 8'h5A}, "R6 character before break intact", 3, 2);
    check(txd === 1'b0, "R6 line low after frame", int'(txd), 0);
    repeat (300) @(negedge clk);
    check(txd === 1'b0 && tx_empty === 1'b0, "R6 break held, queue kept",
          int'({tx_empty, txd}), 0);
    send_break = 1'b0;
    #1;
    check(txd === 1'b1, "R6 line high on break release", int'(txd), 1);
    frame_test({2'd3, 4'b0000, 8'hC3}, "R6 queued char after break", -1, 0);

    // R7 disable mid frame
    push(8'h96);
    frame_test({2'd3, 4'b0000, 8'h96}, "R7 frame completes after disable", 3, 1);
    push(8'h3C);
    repeat (400) @(negedge clk);
    check(txd === 1'b1 && busy === 1'b1 && tx_empty === 1'b0,
          "R7 no start while disabled", int'({tx_empty, busy, txd}), 3);
    tx_en = 1'b1;
    frame_test({2'd3, 4'b0000, 8'h3C}, "R7 start after re-enable", -1, 0);

    // R8 R9 character mode, block disabled
    @(negedge clk);
    fifo_en = 1'b0;
    uart_en = 1'b0;
    push(8'hE1);
    check(busy === 1'b1 && txd === 1'b1, "R8 busy while disabled",
          int'({busy, txd}), 3);
    check(tx_full === 1'b1 && tx_empty === 1'b0, "R9 single entry full",
          int'({tx_full, tx_empty}), 2);
    push(8'h99);
    uart_en = 1'b1;
    frame_test({2'd3, 4'b0000, 8'hE1}, "R9 held character sent", -1, 0);
    check(tx_empty === 1'b1 && busy === 1'b0, "R9 push while full dropped",
          int'({tx_empty, busy}), 2);
    repeat (300) @(negedge clk);
    check(txd === 1'b1, "R9 no second frame", int'(txd), 1);

    // R10 FIFO depth and order
    fifo_en = 1'b1;
    uart_en = 1'b0;
    for (int i = 0; i < 16; i++) push(8'(i * 13 + 7));
    check(tx_full === 1'b1, "R10 full at depth", int'(tx_full), 1);
    push(8'hFF);
    uart_en = 1'b1;
    for (int i = 0; i < 16; i++)
      frame_test({2'd3, 4'b0000, 8'(i * 13 + 7)}, "R10 FIFO order", -1, 0);
    check(tx_empty === 1'b1 && busy === 1'b0, "R10 overflow push dropped",
          int'({tx_empty, busy}), 2);
    repeat (300) @(negedge clk);
    check(txd === 1'b1, "R10 no extra frame", int'(txd), 1);

    // R11 clear-to-send gate
    cts_flow_en = 1'b1;
    cts_n = 1'b1;
    push(8'h6D);
    repeat (300) @(negedge clk);
    check(txd === 1'b1 && tx_empty === 1'b0, "R11 held off by cts_n",
          int'({tx_empty, txd}), 1);
    cts_n = 1'b0;
    exp_frame({2'd3, 4'b0000, 8'h6D}, ef, n);
    capture(n, -1, 0, got);
    check(got[9:0] === ef[9:0], "R11 sent once cts_n low", int'(got[9:0]), int'(ef[9:0]));

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule